// File: doc/BRIEF.md
# Register Scoreboard Dispatch Gate

This block sits between the head of an instruction prefetch queue and the execution units of a pipelined core. Each cycle it looks at the decoded head instruction and decides whether that instruction may issue. The inputs it weighs are the instruction's register operands, the unit it needs, whether it must run alone, the busy state of every execution unit and whether the history buffer has room. When the instruction issues, the gate raises a one-cycle dispatch strobe. When it cannot issue, the gate reports every reason that applies at once.

Register hazards are tracked with one pending-write bit per architectural register. An issued instruction marks its destination as pending. A completion report naming that destination clears the bit again. Up to two completion reports can arrive in the same cycle. A count of in-flight instructions supports serialized instructions: such an instruction waits until the machine is empty, and nothing issues behind it until it has completed.

Top module: `sb_dispatch_gate`

## Requirements
- R1: After reset no register is pending and nothing is in flight, so a valid head with a free unit and a history buffer that has room dispatches in the first cycle.
- R2: With no valid head, dispatch_o is 0 and stall bit 0 (queue empty) is set. The instruction-dependent stall bits 2, 3 and 4 stay 0.
- R3: While hist_full_i is 1, dispatch_o is 0 and stall bit 1 is set, whether or not the head is valid.
- R4: With a valid head, dispatch_o is 0 and stall bit 2 is set while unit_busy_i[head_unit_i] is 1. Busy flags of other units have no effect.
- R5: A dispatch marks its destination register pending from the next cycle. A valid head that reads a pending register through either source then stalls with stall bit 3.
- R6: A completion on either report port clears the named register from the next cycle. Two reports in one cycle clear two registers.
- R7: A valid head whose destination register is pending stalls with stall bit 3.
- R8: Register 0 is never marked pending, so reading or writing it never causes a stall.
- R9: A valid serialized head with any instruction in flight stalls with stall bit 4.
- R10: After a serialized instruction dispatches, every valid head stalls with stall bit 4 until the in-flight count returns to zero.
- R11: stall_o reports all applicable causes at the same time. dispatch_o is 1 exactly when the head is valid and stall_o is zero.
- R12: If a completion and a dispatch name the same register in the same cycle, that register is pending in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| head_valid_i | input | 1 | Queue head holds an instruction |
| head_src_a_i | input | REG_W | First source register index |
| head_src_b_i | input | REG_W | Second source register index |
| head_dst_i | input | REG_W | Destination register index |
| head_unit_i | input | UNIT_W | Execution unit class needed |
| head_serial_i | input | 1 | Head must run alone |
| unit_busy_i | input | NUM_UNITS | Busy flag per execution unit |
| hist_full_i | input | 1 | History buffer has no free entry |
| cmpl_valid_i | input | NUM_CMPL | Completion report valid per port |
| cmpl_dst_i | input | NUM_CMPL*REG_W | Destination index per completion port, port k at bits k*REG_W |
| dispatch_o | output | 1 | Head issues this cycle |
| stall_o | output | 5 | Stall causes: bit0 empty, bit1 history full, bit2 unit busy, bit3 register hazard, bit4 serialize |

## Verification
The bench uses the default build: 32 registers, 4 unit classes and 2 completion ports. At that size every register index, including register 0, is taken through the mark, hazard, same-cycle-clear and release sequence. It is also the size at which every combination of head valid, history-full, unit class and 16-pattern busy mask can be applied one after another. The two completion ports are narrow enough that each port clears a register alone, both clear registers together, and a completion collides with a dispatch to the same register.

// File: rtl/sb_pkg.sv
package sb_pkg;
  localparam int NUM_CAUSES = 5;
  localparam int C_EMPTY  = 0;
  localparam int C_HIST   = 1;
  localparam int C_UNIT   = 2;
  localparam int C_DEP    = 3;
  localparam int C_SERIAL = 4;
  typedef logic [NUM_CAUSES-1:0] stall_vec_t;
endpackage

// File: rtl/sb_dirty_file.sv
module sb_dirty_file #(
  parameter int NUM_REGS = 32,
  parameter int NUM_CMPL = 2,
  localparam int REG_W = $clog2(NUM_REGS)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      set_en_i,
  input  logic [REG_W-1:0]          set_idx_i,
  input  logic [NUM_CMPL-1:0]       clr_valid_i,
  input  logic [NUM_CMPL*REG_W-1:0] clr_idx_i,
  input  logic [REG_W-1:0]          rd_a_i,
  input  logic [REG_W-1:0]          rd_b_i,
  input  logic [REG_W-1:0]          rd_c_i,
  output logic                      hit_o
);
  logic [NUM_REGS-1:0] dirty_q, dirty_d;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    if (i == 0) begin : g_zero
      assign dirty_d[i] = 1'b0;
    end else begin : g_norm
      logic clr, set;
      always_comb begin
        clr = 1'b0;
        for (int k = 0; k < NUM_CMPL; k++)
          if (clr_valid_i[k] && clr_idx_i[k*REG_W +: REG_W] == REG_W'(i)) clr = 1'b1;
        set = set_en_i && (set_idx_i == REG_W'(i));
        // set wins over a same-cycle clear
        dirty_d[i] = set | (dirty_q[i] & ~clr);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) dirty_q <= '0;
    else         dirty_q <= dirty_d;

  assign hit_o = dirty_q[rd_a_i] | dirty_q[rd_b_i] | dirty_q[rd_c_i];

  a_r8_reg0_clean: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dirty_q[0]);

  // R5 and R12: a dispatch marks its destination even against a same-cycle clear
  a_r5_set_marks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_en_i && set_idx_i != '0 |=> dirty_q[$past(set_idx_i)]);

  for (genvar k = 0; k < NUM_CMPL; k++) begin : g_chk
    logic [REG_W-1:0] cidx;
    assign cidx = clr_idx_i[k*REG_W +: REG_W];
    a_r6_clear_port: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_valid_i[k] && !(set_en_i && set_idx_i == cidx) |=> !dirty_q[$past(cidx)]);
  end
endmodule

// File: rtl/sb_inflight.sv
module sb_inflight #(
  parameter int NUM_CMPL = 2,
  parameter int CNT_W    = 6
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                disp_i,
  input  logic                disp_serial_i,
  input  logic [NUM_CMPL-1:0] cmpl_valid_i,
  output logic                idle_o,
  output logic                serial_busy_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d, ncmpl;
  logic             serial_q, serial_d;

  always_comb begin
    ncmpl = '0;
    for (int k = 0; k < NUM_CMPL; k++) ncmpl = ncmpl + CNT_W'(cmpl_valid_i[k]);
    cnt_d = cnt_q + CNT_W'(disp_i) - ncmpl;
    if (disp_i && disp_serial_i) serial_d = 1'b1;
    else if (cnt_d == '0)        serial_d = 1'b0;
    else                         serial_d = serial_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      cnt_q    <= '0;
      serial_q <= 1'b0;
    end else begin
      cnt_q    <= cnt_d;
      serial_q <= serial_d;
    end

  assign idle_o        = (cnt_q == '0);
  assign serial_busy_o = serial_q;

  // R9: completions never outnumber what is in flight
  a_r9_no_underflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ({1'b0, cnt_q} + (CNT_W+1)'(disp_i)) >= {1'b0, ncmpl});

  a_r10_serial_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    serial_q && !disp_i && cnt_q == ncmpl |=> !serial_q);
endmodule

// File: rtl/sb_cause_eval.sv
module sb_cause_eval
  import sb_pkg::*;
#(
  parameter int NUM_UNITS = 4,
  localparam int UNIT_W = $clog2(NUM_UNITS)
) (
  input  logic                 valid_i,
  input  logic [UNIT_W-1:0]    unit_i,
  input  logic [NUM_UNITS-1:0] unit_busy_i,
  input  logic                 hist_full_i,
  input  logic                 dep_hit_i,
  input  logic                 serial_i,
  input  logic                 idle_i,
  input  logic                 serial_busy_i,
  output stall_vec_t           stall_o,
  output logic                 dispatch_o
);
  always_comb begin
    stall_o           = '0;
    stall_o[C_EMPTY]  = !valid_i;
    stall_o[C_HIST]   = hist_full_i;
    stall_o[C_UNIT]   = valid_i && unit_busy_i[unit_i];
    stall_o[C_DEP]    = valid_i && dep_hit_i;
    stall_o[C_SERIAL] = valid_i && (serial_busy_i || (serial_i && !idle_i));
    dispatch_o        = valid_i && (stall_o == '0);
  end
endmodule

// File: rtl/sb_dispatch_gate.sv
module sb_dispatch_gate
  import sb_pkg::*;
#(
  parameter int NUM_REGS  = 32,
  parameter int NUM_UNITS = 4,
  parameter int NUM_CMPL  = 2,
  parameter int CNT_W     = 6,
  localparam int REG_W  = $clog2(NUM_REGS),
  localparam int UNIT_W = $clog2(NUM_UNITS)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      head_valid_i,
  input  logic [REG_W-1:0]          head_src_a_i,
  input  logic [REG_W-1:0]          head_src_b_i,
  input  logic [REG_W-1:0]          head_dst_i,
  input  logic [UNIT_W-1:0]         head_unit_i,
  input  logic                      head_serial_i,
  input  logic [NUM_UNITS-1:0]      unit_busy_i,
  input  logic                      hist_full_i,
  input  logic [NUM_CMPL-1:0]       cmpl_valid_i,
  input  logic [NUM_CMPL*REG_W-1:0] cmpl_dst_i,
  output logic                      dispatch_o,
  output logic [NUM_CAUSES-1:0]     stall_o
);
  logic dep_hit, idle, serial_busy, disp;
  stall_vec_t stall;

  sb_dirty_file #(.NUM_REGS(NUM_REGS), .NUM_CMPL(NUM_CMPL)) u_dirty (
    .clk_i, .rst_ni,
    .set_en_i(disp), .set_idx_i(head_dst_i),
    .clr_valid_i(cmpl_valid_i), .clr_idx_i(cmpl_dst_i),
    .rd_a_i(head_src_a_i), .rd_b_i(head_src_b_i), .rd_c_i(head_dst_i),
    .hit_o(dep_hit)
  );

  sb_inflight #(.NUM_CMPL(NUM_CMPL), .CNT_W(CNT_W)) u_inflight (
    .clk_i, .rst_ni,
    .disp_i(disp), .disp_serial_i(head_serial_i),
    .cmpl_valid_i(cmpl_valid_i),
    .idle_o(idle), .serial_busy_o(serial_busy)
  );

  sb_cause_eval #(.NUM_UNITS(NUM_UNITS)) u_eval (
    .valid_i(head_valid_i), .unit_i(head_unit_i), .unit_busy_i(unit_busy_i),
    .hist_full_i(hist_full_i), .dep_hit_i(dep_hit), .serial_i(head_serial_i),
    .idle_i(idle), .serial_busy_i(serial_busy),
    .stall_o(stall), .dispatch_o(disp)
  );

  assign dispatch_o = disp;
  assign stall_o    = stall;

  a_r2_empty_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !head_valid_i |-> !dispatch_o && stall_o[C_EMPTY]);
  a_r3_hist_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hist_full_i |-> !dispatch_o);
  a_r4_unit_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    head_valid_i && unit_busy_i[head_unit_i] |-> !dispatch_o);
  a_r9_serial_alone: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dispatch_o && head_serial_i |-> idle);
  a_r10_serial_fence: assert property (@(posedge clk_i) disable iff (!rst_ni)
    serial_busy |-> !dispatch_o);
endmodule

// File: tb/sb_dispatch_gate_tb_top.sv
module sb_dispatch_gate_tb_top;
  localparam int NR = 32, NU = 4, NC = 2, RW = 5, UW = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic hv = 0, hser = 0, hist = 0;
  logic [RW-1:0] sa = 0, sb = 0, dst = 0;
  logic [UW-1:0] unit = 0;
  logic [NU-1:0] busy = 0;
  logic [NC-1:0] cv = 0;
  logic [NC*RW-1:0] cr = 0;
  logic disp;
  logic [4:0] stall;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  bit m_dirty [NR];
  int m_outs = 0;
  bit m_ser = 0;

  always #10 clk = ~clk;

  sb_dispatch_gate dut_i (
    .clk_i(clk), .rst_ni(rst_n), .head_valid_i(hv), .head_src_a_i(sa),
    .head_src_b_i(sb), .head_dst_i(dst), .head_unit_i(unit), .head_serial_i(hser),
    .unit_busy_i(busy), .hist_full_i(hist), .cmpl_valid_i(cv), .cmpl_dst_i(cr),
    .dispatch_o(disp), .stall_o(stall)
  );

  task automatic cyc(input bit v, input int a, input int b, input int d, input int u,
                     input bit s, input bit [3:0] bz, input bit h,
                     input bit c0, input int r0, input bit c1, input int r1, input string tag);
    logic [4:0] es;
    bit ed;
    @(negedge clk);
    hv = v; sa = RW'(a); sb = RW'(b); dst = RW'(d); unit = UW'(u); hser = s;
    busy = bz; hist = h; cv = {c1, c0}; cr = {RW'(r1), RW'(r0)};
    #5;
    es = '0;
    es[0] = !v;
    es[1] = h;
    if (v) begin
      es[2] = bz[u];
      es[3] = m_dirty[a] | m_dirty[b] | m_dirty[d];
      es[4] = m_ser || (s && m_outs != 0);
    end
    ed = v && (es == 0);
    n_chk++;
    if (disp !== ed || stall !== es) begin
      n_bad++;
      $display("FAIL %s: disp=%0b stall=%05b expected disp=%0b stall=%05b",
               tag, disp, stall, ed, es);
    end
    @(posedge clk);
    if (c0) m_dirty[r0] = 0;
    if (c1) m_dirty[r1] = 0;
    if (ed && d != 0) m_dirty[d] = 1;
    m_outs = m_outs + int'(ed) - int'(c0) - int'(c1);
    if (ed && s) m_ser = 1;
    else if (m_outs == 0) m_ser = 0;
  endtask

  task automatic drain(input string tag);
    while (m_outs > 0)
      cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, 0, m_outs >= 2, 0, tag);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: expired expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    foreach (m_dirty[i]) m_dirty[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 R2: reset state
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R2 empty after reset");
    cyc(1, 31, 30, 29, 3, 0, 0, 0, 0, 0, 0, 0, "R1 first dispatch");
    cyc(1, 29, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R5 r29 pending");
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, 29, 0, 0, "R6 clear r29");
    drain("R2 drain");
    // R2 R3 R4 R11: exhaustive resource sweep
    for (int u = 0; u < NU; u++)
      for (int bz = 0; bz < 16; bz++)
        for (int h = 0; h < 2; h++)
          for (int v = 0; v < 2; v++) begin
            cyc(v[0], 0, 0, 0, u, 0, bz[3:0], h[0], 0, 0, 0, 0, "R4 R3 R11 sweep");
            drain("R2 sweep drain");
          end
    // R5 R6 R7 R8: every register index
    for (int r = 0; r < NR; r++) begin
      cyc(1, 0, 0, r, 1, 0, 0, 0, 0, 0, 0, 0, "R5 mark");
      cyc(1, 0, r, 0, 2, 0, 0, 0, 0, 0, 0, 0, "R5 R8 src hazard");
      cyc(1, 0, 0, r, 0, 0, 0, 0, r % 2 == 0, r, r % 2 == 1, r, "R7 R8 dst hazard");
      cyc(1, r, 0, 0, 3, 0, 0, 0, 0, 0, 0, 0, "R6 released");
      drain("R2 reg drain");
    end
    // R12: completion and dispatch to the same register
    cyc(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R12 setup");
    cyc(1, 0, 0, 7, 0, 0, 0, 0, 1, 7, 0, 0, "R12 collide");
    cyc(1, 7, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R12 still pending");
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 7, "R12 clear");
    drain("R2 drain");
    // R6: two completions in one cycle
    cyc(1, 0, 0, 9, 0, 0, 0, 0, 0, 0, 0, 0, "R6 mark r9");
    cyc(1, 0, 0, 10, 1, 0, 0, 0, 0, 0, 0, 0, "R6 mark r10");
    cyc(1, 9, 10, 0, 2, 0, 0, 0, 1, 9, 1, 10, "R6 both pending");
    cyc(1, 9, 10, 0, 2, 0, 0, 0, 0, 0, 0, 0, "R6 both cleared");
    drain("R2 drain");
    // R9 R10 R11: serialization
    cyc(1, 0, 0, 3, 1, 0, 0, 0, 0, 0, 0, 0, "R9 setup");
    cyc(1, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0, 0, "R9 waits for in-flight");
    cyc(1, 0, 0, 0, 0, 1, 0, 0, 1, 3, 0, 0, "R9 waits last cycle");
    cyc(1, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0, 0, "R9 serial dispatch");
    cyc(1, 0, 0, 0, 2, 0, 0, 0, 0, 0, 0, 0, "R10 fenced");
    cyc(1, 0, 0, 0, 2, 0, 4'b0100, 1, 0, 0, 0, 0, "R10 R11 multi cause");
    cyc(1, 0, 0, 0, 2, 0, 0, 0, 1, 0, 0, 0, "R10 fenced at completion");
    cyc(1, 0, 0, 0, 2, 0, 0, 0, 0, 0, 0, 0, "R10 released");
    drain("R2 drain");
    // R11: all instruction causes together
    cyc(1, 0, 0, 5, 0, 0, 0, 0, 0, 0, 0, 0, "R11 setup");
    cyc(1, 5, 0, 0, 1, 1, 4'b0010, 1, 0, 0, 0, 0, "R11 four causes");
    cyc(0, 5, 0, 0, 1, 1, 4'b0010, 1, 1, 5, 0, 0, "R2 R3 invalid head masks");
    cyc(1, 5, 0, 0, 1, 1, 4'b1101, 0, 0, 0, 0, 0, "R4 other busy ignored");
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule